// File: doc/BRIEF.md
# Wildcard Priority Flow Table

This block is the lookup stage of a packet switch's forwarding path. For each packet, an upstream parser presents a header key made of ten equal-width fields and the packet's length in bytes. The block compares the key against every valid entry of a small table at the same time. Each entry carries its own per-field wildcard mask, so one table can hold both of these:

- coarse entries that test a single field, such as a destination address;
- fine entries that pin every field.

When several entries match, a stored priority decides the winner. The winner's action is returned one cycle later: forward to a port, or drop. A packet that hits nothing is not discarded. It is flagged as an exception and steered to a dedicated control-plane port.

Each entry keeps a packet counter and a byte counter. Both grow on every win and stop at their maximum value. An entry can also be given an idle lifetime, counted in pulses of an external timer input. The lifetime restarts whenever the entry wins a lookup, and the entry is retired when the lifetime runs out.

A control port lets software load an entry, remove it, or fetch its state, all addressed by an entry index. The state returned includes the counters and the remaining lifetime.

Top module: `flowTable`

## Requirements
- R1: The key packs NUM_FIELDS fields of FIELD_W bits, field f at bits [f*FIELD_W +: FIELD_W]. Bit f of an entry's mask set means field f is not compared for that entry.
- R2: An entry matches when it is valid and every unmasked field equals the key. A mask with one clear bit tests that field alone; an all-zero mask requires an exact match.
- R3: Among matching entries, the one with the largest priority value wins; on equal priority the lower index wins.
- R4: resultValid is high exactly in the cycle after lookupValid was high. On a hit, resultHit=1, resultExcept=0 and resultEntry gives the winner's index. A drop action gives resultDrop=1 with resultPort=0; a forward action gives resultDrop=0 with resultPort set to the stored port.
- R5: On a miss, resultExcept=1, resultHit=0, resultDrop=0 and resultPort=CTRL_PORT.
- R6: Each lookup adds one to the winner's packet count and lookupLen to its byte count. Other entries' counters do not change.
- R7: Both counters stop at their all-ones value instead of wrapping.
- R8: With a nonzero lifetime T, each tick pulse lowers the remaining count. The entry becomes invalid on the tick that brings the count to zero. A win in the same cycle as a tick reloads T instead of counting down. A lifetime of 0 never expires.
- R9: Writing an entry sets it valid, loads its fields, clears both counters and loads the remaining count with T. A lookup in the same cycle as a write is judged against the previous contents, and the written entry takes no statistics update from it.
- R10: Deleting an entry makes it invalid and zeroes its remaining count. If write and delete are raised together, the write is carried out.
- R11: rdValid is high exactly in the cycle after ctlRead. It returns the valid bit, priority, packet count, byte count and remaining count of entry ctlIndex, as they stood before that clock edge.
- R12: After reset every entry is invalid with zero counters, and resultValid and rdValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A key is presented this cycle |
| lookupKey | input | NUM_FIELDS*FIELD_W | Header key |
| lookupLen | input | LEN_W | Packet length in bytes |
| tick | input | 1 | Lifetime timer pulse |
| resultValid | output | 1 | Lookup result present |
| resultHit | output | 1 | Some entry matched |
| resultExcept | output | 1 | Miss, sent to control port |
| resultDrop | output | 1 | Winner's action is drop |
| resultPort | output | PORT_W | Output port of the result |
| resultEntry | output | log2(ENTRIES) | Index of the winning entry |
| ctlWrite | input | 1 | Load entry ctlIndex |
| ctlDelete | input | 1 | Remove entry ctlIndex |
| ctlRead | input | 1 | Fetch state of entry ctlIndex |
| ctlIndex | input | log2(ENTRIES) | Entry addressed by the control port |
| ctlKey | input | NUM_FIELDS*FIELD_W | Match values to load |
| ctlMask | input | NUM_FIELDS | Per-field wildcard bits to load |
| ctlPrio | input | PRIO_W | Priority to load |
| ctlDrop | input | 1 | Action to load: 1 drop, 0 forward |
| ctlPort | input | PORT_W | Forward port to load |
| ctlTimeout | input | TO_W | Idle lifetime in ticks, 0 for none |
| rdValid | output | 1 | Read response present |
| rdEntryValid | output | 1 | Read: entry valid bit |
| rdPrio | output | PRIO_W | Read: priority |
| rdPkts | output | PKT_W | Read: packet count |
| rdBytes | output | BYTE_W | Read: byte count |
| rdRemain | output | TO_W | Read: remaining lifetime |

## Verification
The assertions assume that lookupValid and ctlRead stay low while rstN is low. They also assume that ENTRIES is a power of two, so every ctlIndex names a real entry. The bench drives each input on the falling edge and releases lookupValid and ctlRead during reset. It keeps every index within the eight entries of its configuration. Counter and lifetime widths are made small so that saturation and expiry are reached within a few dozen vectors.

// File: rtl/flowPkg.sv
`timescale 1ns/1ps
package flowPkg;
  // control strobes handed from the control block to the datapath
  typedef struct packed {
    logic wr;
    logic del;
  } ctlStrobe_t;
endpackage

// File: rtl/flowEntry.sv
`timescale 1ns/1ps
module flowEntry #(
  parameter int NUM_FIELDS = 10,
  parameter int FIELD_W    = 8,
  parameter int PRIO_W     = 4,
  parameter int PORT_W     = 4,
  parameter int LEN_W      = 12,
  parameter int PKT_W      = 16,
  parameter int BYTE_W     = 24,
  parameter int TO_W       = 8,
  localparam int KEY_W     = NUM_FIELDS * FIELD_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  delEn,
  input  logic                  hitEn,
  input  logic                  tick,
  input  logic [KEY_W-1:0]      wrKey,
  input  logic [NUM_FIELDS-1:0] wrMask,
  input  logic [PRIO_W-1:0]     wrPrio,
  input  logic                  wrDrop,
  input  logic [PORT_W-1:0]     wrPort,
  input  logic [TO_W-1:0]       wrTimeout,
  input  logic [KEY_W-1:0]      lookupKey,
  input  logic [LEN_W-1:0]      pktLen,
  output logic                  match,
  output logic                  valid,
  output logic [PRIO_W-1:0]     prio,
  output logic                  actDrop,
  output logic [PORT_W-1:0]     actPort,
  output logic [PKT_W-1:0]      pkts,
  output logic [BYTE_W-1:0]     bytes,
  output logic [TO_W-1:0]       remain
);
  localparam int SUM_W = ((BYTE_W > LEN_W) ? BYTE_W : LEN_W) + 1;

  logic [KEY_W-1:0]      key;
  logic [NUM_FIELDS-1:0] mask;
  logic [TO_W-1:0]       toCfg;
  logic [NUM_FIELDS-1:0] fieldOk;

  // per-field compare, a set mask bit accepts any value
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : gField
    assign fieldOk[f] = mask[f] |
      (key[f*FIELD_W +: FIELD_W] == lookupKey[f*FIELD_W +: FIELD_W]);
  end

  assign match = valid & (&fieldOk);

  // saturating counter updates
  logic [PKT_W-1:0]  pktNext;
  logic [SUM_W-1:0]  byteSum;
  logic [BYTE_W-1:0] byteNext;

  always_comb begin
    pktNext  = (pkts == {PKT_W{1'b1}}) ? pkts : pkts + 1'b1;
    byteSum  = SUM_W'(bytes) + SUM_W'(pktLen);
    byteNext = (byteSum > SUM_W'({BYTE_W{1'b1}})) ? {BYTE_W{1'b1}}
                                                   : byteSum[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid   <= 1'b0;
      key     <= '0;
      mask    <= '0;
      prio    <= '0;
      actDrop <= 1'b0;
      actPort <= '0;
      toCfg   <= '0;
      remain  <= '0;
      pkts    <= '0;
      bytes   <= '0;
    end else if (wrEn) begin
      valid   <= 1'b1;
      key     <= wrKey;
      mask    <= wrMask;
      prio    <= wrPrio;
      actDrop <= wrDrop;
      actPort <= wrPort;
      toCfg   <= wrTimeout;
      remain  <= wrTimeout;
      pkts    <= '0;
      bytes   <= '0;
    end else if (delEn) begin
      valid  <= 1'b0;
      remain <= '0;
    end else if (hitEn) begin
      pkts   <= pktNext;
      bytes  <= byteNext;
      remain <= toCfg;
    end else if (tick && valid && (toCfg != '0)) begin
      if (remain <= TO_W'(1)) begin
        valid  <= 1'b0;
        remain <= '0;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flowSelect.sv
`timescale 1ns/1ps
module flowSelect #(
  parameter int ENTRIES = 8,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] match,
  input  logic [PRIO_W-1:0]  prio [ENTRIES],
  output logic               anyHit,
  output logic [IDX_W-1:0]   winIdx
);
  logic [PRIO_W-1:0] bestPrio;

  // strict greater-than keeps the lower index on equal priority
  always_comb begin
    anyHit   = 1'b0;
    winIdx   = '0;
    bestPrio = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i] && (!anyHit || (prio[i] > bestPrio))) begin
        anyHit   = 1'b1;
        winIdx   = IDX_W'(i);
        bestPrio = prio[i];
      end
    end
  end
endmodule

// File: rtl/flowDatapath.sv
`timescale 1ns/1ps
module flowDatapath
  import flowPkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int NUM_FIELDS = 10,
  parameter int FIELD_W    = 8,
  parameter int PRIO_W     = 4,
  parameter int PORT_W     = 4,
  parameter int LEN_W      = 12,
  parameter int PKT_W      = 16,
  parameter int BYTE_W     = 24,
  parameter int TO_W       = 8,
  parameter int CTRL_PORT  = 15,
  localparam int KEY_W     = NUM_FIELDS * FIELD_W,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [ENTRIES-1:0]    entSel,
  input  logic                  lookupValid,
  input  logic [KEY_W-1:0]      lookupKey,
  input  logic [LEN_W-1:0]      lookupLen,
  input  logic                  tick,
  input  logic [KEY_W-1:0]      ctlKey,
  input  logic [NUM_FIELDS-1:0] ctlMask,
  input  logic [PRIO_W-1:0]     ctlPrio,
  input  logic                  ctlDrop,
  input  logic [PORT_W-1:0]     ctlPort,
  input  logic [TO_W-1:0]       ctlTimeout,
  output logic                  resultValid,
  output logic                  resultHit,
  output logic                  resultExcept,
  output logic                  resultDrop,
  output logic [PORT_W-1:0]     resultPort,
  output logic [IDX_W-1:0]      resultEntry,
  output logic [ENTRIES-1:0]    entValid,
  output logic [PRIO_W-1:0]     entPrio   [ENTRIES],
  output logic [PKT_W-1:0]      entPkts   [ENTRIES],
  output logic [BYTE_W-1:0]     entBytes  [ENTRIES],
  output logic [TO_W-1:0]       entRemain [ENTRIES]
);
  logic [ENTRIES-1:0] entMatch;
  logic               entDrop [ENTRIES];
  logic [PORT_W-1:0]  entPort [ENTRIES];
  logic               anyHit;
  logic [IDX_W-1:0]   winIdx;

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    logic hitEn;
    assign hitEn = lookupValid & anyHit & (winIdx == IDX_W'(i));

    flowEntry #(
      .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .PRIO_W(PRIO_W),
      .PORT_W(PORT_W), .LEN_W(LEN_W), .PKT_W(PKT_W),
      .BYTE_W(BYTE_W), .TO_W(TO_W)
    ) uEntry (
      .clk       (clk),
      .rstN      (rstN),
      .wrEn      (strobe.wr & entSel[i]),
      .delEn     (strobe.del & entSel[i]),
      .hitEn     (hitEn),
      .tick      (tick),
      .wrKey     (ctlKey),
      .wrMask    (ctlMask),
      .wrPrio    (ctlPrio),
      .wrDrop    (ctlDrop),
      .wrPort    (ctlPort),
      .wrTimeout (ctlTimeout),
      .lookupKey (lookupKey),
      .pktLen    (lookupLen),
      .match     (entMatch[i]),
      .valid     (entValid[i]),
      .prio      (entPrio[i]),
      .actDrop   (entDrop[i]),
      .actPort   (entPort[i]),
      .pkts      (entPkts[i]),
      .bytes     (entBytes[i]),
      .remain    (entRemain[i])
    );
  end

  flowSelect #(.ENTRIES(ENTRIES), .PRIO_W(PRIO_W)) uSelect (
    .match  (entMatch),
    .prio   (entPrio),
    .anyHit (anyHit),
    .winIdx (winIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid  <= 1'b0;
      resultHit    <= 1'b0;
      resultExcept <= 1'b0;
      resultDrop   <= 1'b0;
      resultPort   <= '0;
      resultEntry  <= '0;
    end else begin
      resultValid <= lookupValid;
      if (lookupValid) begin
        resultHit    <= anyHit;
        resultExcept <= ~anyHit;
        resultDrop   <= anyHit & entDrop[winIdx];
        resultEntry  <= anyHit ? winIdx : '0;
        if (!anyHit)               resultPort <= PORT_W'(CTRL_PORT);
        else if (entDrop[winIdx])  resultPort <= '0;
        else                       resultPort <= entPort[winIdx];
      end
    end
  end
endmodule

// File: rtl/flowCtl.sv
`timescale 1ns/1ps
module flowCtl
  import flowPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PRIO_W  = 4,
  parameter int PKT_W   = 16,
  parameter int BYTE_W  = 24,
  parameter int TO_W    = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWrite,
  input  logic               ctlDelete,
  input  logic               ctlRead,
  input  logic [IDX_W-1:0]   ctlIndex,
  input  logic [ENTRIES-1:0] entValid,
  input  logic [PRIO_W-1:0]  entPrio   [ENTRIES],
  input  logic [PKT_W-1:0]   entPkts   [ENTRIES],
  input  logic [BYTE_W-1:0]  entBytes  [ENTRIES],
  input  logic [TO_W-1:0]    entRemain [ENTRIES],
  output ctlStrobe_t         strobe,
  output logic [ENTRIES-1:0] entSel,
  output logic               rdValid,
  output logic               rdEntryValid,
  output logic [PRIO_W-1:0]  rdPrio,
  output logic [PKT_W-1:0]   rdPkts,
  output logic [BYTE_W-1:0]  rdBytes,
  output logic [TO_W-1:0]    rdRemain
);
  // write takes precedence over delete
  always_comb begin
    strobe.wr  = ctlWrite;
    strobe.del = ctlDelete & ~ctlWrite;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : gSel
    assign entSel[i] = (ctlIndex == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid      <= 1'b0;
      rdEntryValid <= 1'b0;
      rdPrio       <= '0;
      rdPkts       <= '0;
      rdBytes      <= '0;
      rdRemain     <= '0;
    end else begin
      rdValid <= ctlRead;
      if (ctlRead) begin
        rdEntryValid <= entValid[ctlIndex];
        rdPrio       <= entPrio[ctlIndex];
        rdPkts       <= entPkts[ctlIndex];
        rdBytes      <= entBytes[ctlIndex];
        rdRemain     <= entRemain[ctlIndex];
      end
    end
  end
endmodule

// File: rtl/flowTable.sv
`timescale 1ns/1ps
module flowTable
  import flowPkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int NUM_FIELDS = 10,
  parameter int FIELD_W    = 8,
  parameter int PRIO_W     = 4,
  parameter int PORT_W     = 4,
  parameter int LEN_W      = 12,
  parameter int PKT_W      = 16,
  parameter int BYTE_W     = 24,
  parameter int TO_W       = 8,
  parameter int CTRL_PORT  = 15,
  localparam int KEY_W     = NUM_FIELDS * FIELD_W,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lookupValid,
  input  logic [KEY_W-1:0]      lookupKey,
  input  logic [LEN_W-1:0]      lookupLen,
  input  logic                  tick,
  output logic                  resultValid,
  output logic                  resultHit,
  output logic                  resultExcept,
  output logic                  resultDrop,
  output logic [PORT_W-1:0]     resultPort,
  output logic [IDX_W-1:0]      resultEntry,
  input  logic                  ctlWrite,
  input  logic                  ctlDelete,
  input  logic                  ctlRead,
  input  logic [IDX_W-1:0]      ctlIndex,
  input  logic [KEY_W-1:0]      ctlKey,
  input  logic [NUM_FIELDS-1:0] ctlMask,
  input  logic [PRIO_W-1:0]     ctlPrio,
  input  logic                  ctlDrop,
  input  logic [PORT_W-1:0]     ctlPort,
  input  logic [TO_W-1:0]       ctlTimeout,
  output logic                  rdValid,
  output logic                  rdEntryValid,
  output logic [PRIO_W-1:0]     rdPrio,
  output logic [PKT_W-1:0]      rdPkts,
  output logic [BYTE_W-1:0]     rdBytes,
  output logic [TO_W-1:0]       rdRemain
);
  ctlStrobe_t         strobe;
  logic [ENTRIES-1:0] entSel;
  logic [ENTRIES-1:0] entValid;
  logic [PRIO_W-1:0]  entPrio   [ENTRIES];
  logic [PKT_W-1:0]   entPkts   [ENTRIES];
  logic [BYTE_W-1:0]  entBytes  [ENTRIES];
  logic [TO_W-1:0]    entRemain [ENTRIES];

  flowCtl #(
    .ENTRIES(ENTRIES), .PRIO_W(PRIO_W), .PKT_W(PKT_W),
    .BYTE_W(BYTE_W), .TO_W(TO_W)
  ) uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .ctlWrite     (ctlWrite),
    .ctlDelete    (ctlDelete),
    .ctlRead      (ctlRead),
    .ctlIndex     (ctlIndex),
    .entValid     (entValid),
    .entPrio      (entPrio),
    .entPkts      (entPkts),
    .entBytes     (entBytes),
    .entRemain    (entRemain),
    .strobe       (strobe),
    .entSel       (entSel),
    .rdValid      (rdValid),
    .rdEntryValid (rdEntryValid),
    .rdPrio       (rdPrio),
    .rdPkts       (rdPkts),
    .rdBytes      (rdBytes),
    .rdRemain     (rdRemain)
  );

  flowDatapath #(
    .ENTRIES(ENTRIES), .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W),
    .PRIO_W(PRIO_W), .PORT_W(PORT_W), .LEN_W(LEN_W), .PKT_W(PKT_W),
    .BYTE_W(BYTE_W), .TO_W(TO_W), .CTRL_PORT(CTRL_PORT)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .entSel       (entSel),
    .lookupValid  (lookupValid),
    .lookupKey    (lookupKey),
    .lookupLen    (lookupLen),
    .tick         (tick),
    .ctlKey       (ctlKey),
    .ctlMask      (ctlMask),
    .ctlPrio      (ctlPrio),
    .ctlDrop      (ctlDrop),
    .ctlPort      (ctlPort),
    .ctlTimeout   (ctlTimeout),
    .resultValid  (resultValid),
    .resultHit    (resultHit),
    .resultExcept (resultExcept),
    .resultDrop   (resultDrop),
    .resultPort   (resultPort),
    .resultEntry  (resultEntry),
    .entValid     (entValid),
    .entPrio      (entPrio),
    .entPkts      (entPkts),
    .entBytes     (entBytes),
    .entRemain    (entRemain)
  );
endmodule

// File: rtl/flowTableChk.sv
`timescale 1ns/1ps
module flowTableChk #(
  parameter int PORT_W    = 4,
  parameter int CTRL_PORT = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic              ctlRead,
  input logic              resultValid,
  input logic              resultHit,
  input logic              resultExcept,
  input logic              resultDrop,
  input logic [PORT_W-1:0] resultPort,
  input logic              rdValid
);
  // R4
  result_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> resultValid);

  // R4
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !resultValid);

  // R4
  hit_not_except_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultHit) |-> !resultExcept);

  // R4
  drop_port_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultDrop) |-> (resultHit && resultPort == '0));

  // R5
  miss_to_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !resultHit) |->
      (resultExcept && !resultDrop && resultPort == PORT_W'(CTRL_PORT)));

  // R11
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlRead |=> rdValid);

  // R11
  no_spurious_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlRead |=> !rdValid);
endmodule

bind flowTable flowTableChk #(.PORT_W(PORT_W), .CTRL_PORT(CTRL_PORT)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .lookupValid  (lookupValid),
  .ctlRead      (ctlRead),
  .resultValid  (resultValid),
  .resultHit    (resultHit),
  .resultExcept (resultExcept),
  .resultDrop   (resultDrop),
  .resultPort   (resultPort),
  .rdValid      (rdValid)
);

// File: tb/sim_flowTable.sv
`timescale 1ns/1ps
module sim_flowTable;
  localparam int ENT = 8;
  localparam int NF  = 10;
  localparam int FW  = 8;
  localparam int KW  = NF * FW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [KW-1:0] lookupKey = '0;
  logic [11:0] lookupLen = '0;
  logic tick = 1'b0;
  logic ctlWrite = 1'b0, ctlDelete = 1'b0, ctlRead = 1'b0;
  logic [2:0] ctlIndex = '0;
  logic [KW-1:0] ctlKey = '0;
  logic [NF-1:0] ctlMask = '0;
  logic [3:0] ctlPrio = '0;
  logic ctlDrop = 1'b0;
  logic [3:0] ctlPort = '0;
  logic [3:0] ctlTimeout = '0;

  logic resultValid, resultHit, resultExcept, resultDrop;
  logic [3:0] resultPort;
  logic [2:0] resultEntry;
  logic rdValid, rdEntryValid;
  logic [3:0] rdPrio, rdPkts, rdRemain;
  logic [7:0] rdBytes;

  always #4 clk = ~clk;

  flowTable #(
    .ENTRIES(ENT), .NUM_FIELDS(NF), .FIELD_W(FW), .PRIO_W(4), .PORT_W(4),
    .LEN_W(12), .PKT_W(4), .BYTE_W(8), .TO_W(4), .CTRL_PORT(15)
  ) u0 (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupKey(lookupKey),
    .lookupLen(lookupLen), .tick(tick), .resultValid(resultValid),
    .resultHit(resultHit), .resultExcept(resultExcept), .resultDrop(resultDrop),
    .resultPort(resultPort), .resultEntry(resultEntry), .ctlWrite(ctlWrite),
    .ctlDelete(ctlDelete), .ctlRead(ctlRead), .ctlIndex(ctlIndex),
    .ctlKey(ctlKey), .ctlMask(ctlMask), .ctlPrio(ctlPrio), .ctlDrop(ctlDrop),
    .ctlPort(ctlPort), .ctlTimeout(ctlTimeout), .rdValid(rdValid),
    .rdEntryValid(rdEntryValid), .rdPrio(rdPrio), .rdPkts(rdPkts),
    .rdBytes(rdBytes), .rdRemain(rdRemain)
  );

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // reference table built from the requirements
  bit          mV   [ENT];
  logic [KW-1:0] mK [ENT];
  logic [NF-1:0] mM [ENT];
  int          mP   [ENT];
  bit          mD   [ENT];
  int          mPort[ENT];
  int          mTo  [ENT];
  int          mRem [ENT];
  int          mPk  [ENT];
  int          mBy  [ENT];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int expWin(input logic [KW-1:0] k);
    int w = -1;
    for (int i = 0; i < ENT; i++) begin
      bit ok = mV[i];
      for (int f = 0; f < NF; f++)
        if (!mM[i][f] && k[f*FW +: FW] != mK[i][f*FW +: FW]) ok = 0;
      if (ok && (w < 0 || mP[i] > mP[w])) w = i;
    end
    return w;
  endfunction

  function automatic logic [KW-1:0] mkKey(input int base, input int f2);
    logic [KW-1:0] k;
    for (int f = 0; f < NF; f++) k[f*FW +: FW] = 8'(base + f);
    k[2*FW +: FW] = 8'(f2);
    return k;
  endfunction

  // one clock of stimulus with any mix of operations, then the checks
  task automatic cycleOp(input bit doLook, input logic [KW-1:0] lk, input int len,
                         input bit doWr, input bit doDel, input bit doTick,
                         input int idx, input logic [KW-1:0] wk,
                         input logic [NF-1:0] wm, input int wp, input bit wd,
                         input int wport, input int wto, input string req);
    int w;
    bit eHit, eDrop;
    int ePort;
    @(negedge clk);
    lookupValid = doLook; lookupKey = lk; lookupLen = 12'(len);
    ctlWrite = doWr; ctlDelete = doDel; tick = doTick;
    ctlIndex = 3'(idx); ctlKey = wk; ctlMask = wm; ctlPrio = 4'(wp);
    ctlDrop = wd; ctlPort = 4'(wport); ctlTimeout = 4'(wto);
    w = doLook ? expWin(lk) : -1;
    eHit  = (w >= 0);
    eDrop = eHit && mD[w];
    ePort = !eHit ? 15 : (eDrop ? 0 : mPort[w]);
    @(posedge clk);
    for (int i = 0; i < ENT; i++) begin
      if (doWr && i == idx) begin
        mV[i] = 1; mK[i] = wk; mM[i] = wm; mP[i] = wp; mD[i] = wd;
        mPort[i] = wport; mTo[i] = wto; mRem[i] = wto; mPk[i] = 0; mBy[i] = 0;
      end else if (doDel && i == idx) begin
        mV[i] = 0; mRem[i] = 0;
      end else if (i == w) begin
        mPk[i] = (mPk[i] < 15) ? mPk[i] + 1 : 15;
        mBy[i] = (mBy[i] + len > 255) ? 255 : mBy[i] + len;
        mRem[i] = mTo[i];
      end else if (doTick && mV[i] && mTo[i] != 0) begin
        if (mRem[i] <= 1) begin mV[i] = 0; mRem[i] = 0; end
        else mRem[i] = mRem[i] - 1;
      end
    end
    @(negedge clk);
    lookupValid = 0; ctlWrite = 0; ctlDelete = 0; tick = 0;
    if (doLook) begin
      chk(req, "resultValid", 64'(resultValid), 64'd1);
      chk(req, "hit", 64'(resultHit), 64'(eHit));
      chk(req, "except", 64'(resultExcept), 64'(!eHit));
      chk(req, "drop", 64'(resultDrop), 64'(eDrop));
      chk(req, "port", 64'(resultPort), 64'(ePort));
      if (eHit) chk(req, "entry", 64'(resultEntry), 64'(w));
    end
  endtask

  task automatic lookup(input logic [KW-1:0] k, input int len, input string req);
    cycleOp(1, k, len, 0, 0, 0, 0, '0, '0, 0, 0, 0, 0, req);
  endtask

  task automatic writeE(input int idx, input logic [KW-1:0] k, input logic [NF-1:0] m,
                        input int p, input bit d, input int port, input int to);
    cycleOp(0, '0, 0, 1, 0, 0, idx, k, m, p, d, port, to, "R9");
  endtask

  task automatic tickOnce();
    cycleOp(0, '0, 0, 0, 0, 1, 0, '0, '0, 0, 0, 0, 0, "R8");
  endtask

  task automatic readE(input int idx, input string req);
    @(negedge clk);
    ctlRead = 1; ctlIndex = 3'(idx);
    @(posedge clk);
    @(negedge clk);
    ctlRead = 0;
    chk(req, "rdValid", 64'(rdValid), 64'd1);
    chk(req, "rdEntryValid", 64'(rdEntryValid), 64'(mV[idx]));
    chk(req, "rdPrio", 64'(rdPrio), 64'(mP[idx]));
    chk(req, "rdPkts", 64'(rdPkts), 64'(mPk[idx]));
    chk(req, "rdBytes", 64'(rdBytes), 64'(mBy[idx]));
    chk(req, "rdRemain", 64'(rdRemain), 64'(mRem[idx]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [KW-1:0] kExact, k4, k3, kv;
    for (int i = 0; i < ENT; i++) begin
      mV[i] = 0; mK[i] = '0; mM[i] = '0; mP[i] = 0; mD[i] = 0;
      mPort[i] = 0; mTo[i] = 0; mRem[i] = 0; mPk[i] = 0; mBy[i] = 0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk("R12", "resultValid", 64'(resultValid), 64'd0);
    chk("R12", "rdValid", 64'(rdValid), 64'd0);
    rstN = 1;
    for (int i = 0; i < ENT; i++) readE(i, "R12");

    // R5: empty table, every key is an exception
    lookup(mkKey(8'h20, 8'h33), 64, "R5");

    // R2: routing-style entry that tests field 2 only, swept over all values
    writeE(0, mkKey(0, 8'hA5), ~10'b0000000100, 1, 0, 3, 0);
    for (int v = 0; v < 256; v++) begin
      for (int f = 0; f < NF; f++) kv[f*FW +: FW] = 8'(v * 7 + f * 13);
      kv[2*FW +: FW] = 8'(v);
      lookup(kv, v + 1, "R2");
    end
    readE(0, "R6");

    // R3: equal priority, lower index wins
    kExact = mkKey(8'h10, 8'hA5);
    writeE(5, kExact, '0, 1, 1, 0, 0);
    lookup(kExact, 10, "R3");
    // R3: higher priority wins; R4 forward then drop action
    writeE(6, kExact, '0, 7, 0, 9, 0);
    lookup(kExact, 10, "R4");
    writeE(6, kExact, '0, 7, 1, 9, 0);
    lookup(kExact, 10, "R4");
    // R1: flipping any one field breaks the exact entries
    for (int f = 0; f < NF; f++) begin
      kv = kExact;
      kv[f*FW +: FW] = kv[f*FW +: FW] ^ 8'hFF;
      lookup(kv, 5, "R1");
    end
    // R3: priority sweep of a competing entry
    for (int p = 0; p < 16; p++) begin
      writeE(7, kExact, '0, p, 0, 12, 0);
      lookup(kExact, 3, "R3");
    end

    // R6 / R7: counts and saturation
    k4 = mkKey(8'h40, 8'h00);
    writeE(4, k4, '0, 15, 0, 6, 0);
    for (int n = 0; n < 3; n++) lookup(k4, 20, "R6");
    readE(4, "R6");
    for (int n = 0; n < 17; n++) lookup(k4, 20, "R7");
    readE(4, "R7");

    // R8: idle lifetime
    k3 = mkKey(8'h30, 8'h01);
    writeE(3, k3, '0, 15, 0, 2, 3);
    tickOnce(); tickOnce();
    readE(3, "R8");
    cycleOp(1, k3, 40, 0, 0, 1, 0, '0, '0, 0, 0, 0, 0, "R8");
    readE(3, "R8");
    tickOnce(); tickOnce();
    readE(3, "R8");
    tickOnce();
    readE(3, "R8");
    lookup(k3, 40, "R8");
    readE(0, "R8");

    // R9: write and lookup together on the winning entry
    cycleOp(1, k4, 30, 1, 0, 0, 4, mkKey(8'h50, 8'h02), '0, 15, 0, 8, 0, "R9");
    readE(4, "R9");
    lookup(k4, 30, "R9");
    lookup(mkKey(8'h50, 8'h02), 30, "R9");

    // R10: delete, and write beating delete
    cycleOp(0, '0, 0, 0, 1, 0, 6, '0, '0, 0, 0, 0, 0, "R10");
    lookup(kExact, 2, "R10");
    readE(6, "R10");
    cycleOp(0, '0, 0, 1, 1, 0, 1, mkKey(8'h60, 8'h03), '0, 2, 0, 5, 0, "R10");
    readE(1, "R10");
    lookup(mkKey(8'h60, 8'h03), 9, "R10");

    // R11: final readback of the whole table
    for (int i = 0; i < ENT; i++) readE(i, "R11");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule